// File: doc/BRIEF.md
# Hit-Channel Register and Readout Sequencer

This block keeps one hit flag for each of 64 detector channels. A discriminator pulse on a channel raises its flag. Each flag then ages against strobes that mark the moment the analog write pointer passes cell zero. A flag drops on the second such strobe after it was last raised, so a hit stays visible for between one and two full write cycles. A fresh hit on a flag that is already set restarts its aging, which adds one full write cycle to its life. While the write phase runs, any discriminator activity fires a fixed-width trigger pulse. A parallel snapshot port shows the flag vector at all times, so it can be read after the write phase stops and before readout starts.

Readout is started with a single strobe. At that edge the sequencer chooses the channel set from the selected mode: every channel, only the channels whose flag is set, or a supplied mask. At the same edge it clears the hit register. It then emits the chosen channel indices in ascending order, one per clock, each with a valid strobe. The final index is tagged, and a one-cycle done pulse follows it. If the set is empty, done comes at once. While readout is in progress, discriminator pulses and wrap strobes have no effect.

The sequencer has three states. IDLE waits for the start strobe. SCAN emits indices. DONE marks the end. The transitions are:
- IDLE→SCAN on start with a non-empty set.
- IDLE→DONE on start with an empty set.
- SCAN→SCAN while indices remain.
- SCAN→DONE on the final index.
- DONE→IDLE always.

Top module: `hit_flag_sequencer`

## Requirements
- R1: While reset is asserted and right after it, snap_o is all zero, and mult_o, ch_valid_o, ch_last_o, rd_busy_o and rd_done_o are 0.
- R2: When disc_i[c] is 1 at a rising edge outside readout, snap_o[c] is 1 from that edge on. A flag can only rise on an edge where its disc_i bit was 1.
- R3: A set flag stays set through the first wrap_i strobe after it was raised. It clears on the edge of the second strobe.
- R4: A hit on a flag that is already set restarts its aging, so two further wrap strobes are needed to clear it. A hit and a wrap on the same edge count as a fresh hit.
- R5: When any disc_i bit is 1 at an edge outside readout, mult_o is 1 for exactly the 2 cycles after that edge. A further hit during the pulse restarts the 2-cycle count.
- R6: On the edge that accepts rd_start_i, all flags clear. While rd_busy_o is 1, disc_i and wrap_i have no effect: snap_o stays zero and mult_o is not retriggered.
- R7: The rd_mode_i encoding is 0 = all channels, 1 = channels whose flag was set at the start edge, and 2 or 3 = the channels set in rd_mask_i at the start edge. Selected indices appear in ascending order, one per cycle with ch_valid_o = 1, starting the cycle after the start edge. ch_last_o is 1 only with the final index.
- R8: If the selected set is empty, rd_done_o is 1 in the cycle right after the start edge, and no valid index appears.
- R9: rd_done_o pulses for one cycle right after the last index. rd_busy_o is low the cycle after that. rd_start_i is ignored while rd_busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disc_i | input | 64 | Per-channel discriminator pulses |
| wrap_i | input | 1 | Write pointer crossed cell zero |
| snap_o | output | 64 | Parallel view of the hit flags |
| mult_o | output | 1 | Trigger / multiplicity pulse |
| rd_start_i | input | 1 | Start readout strobe |
| rd_mode_i | input | 2 | Channel selection mode |
| rd_mask_i | input | 64 | Channel mask for mask mode |
| ch_valid_o | output | 1 | Channel index valid |
| ch_idx_o | output | 6 | Channel index to multiplex out |
| ch_last_o | output | 1 | Final index of this readout |
| rd_busy_o | output | 1 | Readout in progress |
| rd_done_o | output | 1 | Readout finished, one cycle |

## Verification
Each flag change is due at the edge that samples the discriminator or wrap strobe. The trigger pulse covers the two cycles after a hit. The first readout index, or done for an empty set, is due in the cycle after the start edge, and the others follow one per cycle. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It compares outputs a quarter period after that rising edge, so every comparison sees exactly one register stage of effect. During readout it drives random hits and wraps, and it holds start high, so that the outputs show whether those inputs had any effect.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    typedef enum logic [1:0] {
        MODE_ALL      = 2'd0,
        MODE_HIT      = 2'd1,
        MODE_MASK     = 2'd2,
        MODE_MASK_ALT = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hfs_hit_cell.sv
module hfs_hit_cell #(
    parameter int LIFE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic hit_i,
    input  logic wrap_i,
    output logic flag_o
);
    localparam int CW = $clog2(LIFE + 1);

    logic          flag_q;
    logic [CW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            age_q  <= '0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
            age_q  <= '0;
        end else if (hit_i) begin
            flag_q <= 1'b1;
            age_q  <= '0;
        end else if (wrap_i && flag_q) begin
            if (age_q == CW'(LIFE - 1)) begin
                flag_q <= 1'b0;
                age_q  <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/hfs_mult_pulse.sv
module hfs_mult_pulse #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic mult_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trig_i) begin
            left_q <= PW'(PULSE_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign mult_o = (left_q != '0);
endmodule

// File: rtl/hfs_rd_seq.sv
module hfs_rd_seq
    import hfs_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [1:0]                mode_i,
    input  logic [NUM_CH-1:0]         mask_i,
    input  logic [NUM_CH-1:0]         flags_i,
    output logic                      clr_o,
    output logic                      valid_o,
    output logic [$clog2(NUM_CH)-1:0] idx_o,
    output logic                      last_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int IW = $clog2(NUM_CH);

    seq_state_e        state_q, state_d;
    logic [NUM_CH-1:0] pend_q, pend_d;
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] rest;
    logic [IW-1:0]     low_idx;
    logic              accept;

    always_comb begin
        unique case (rd_mode_e'(mode_i))
            MODE_ALL:      sel = '1;
            MODE_HIT:      sel = flags_i;
            MODE_MASK:     sel = mask_i;
            MODE_MASK_ALT: sel = mask_i;
            default:       sel = mask_i;
        endcase
    end

    always_comb begin
        low_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_q[i]) low_idx = IW'(i);
        end
    end

    assign rest   = pend_q & (pend_q - 1'b1);
    assign accept = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    pend_d  = sel;
                    state_d = (sel == '0) ? ST_DONE : ST_SCAN;
                end
            end
            ST_SCAN: begin
                pend_d = rest;
                if (rest == '0) state_d = ST_DONE;
            end
            ST_DONE: begin
                pend_d  = '0;
                state_d = ST_IDLE;
            end
            default: begin
                pend_d  = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        clr_o   = accept;
        valid_o = 1'b0;
        last_o  = 1'b0;
        done_o  = 1'b0;
        busy_o  = 1'b1;
        idx_o   = '0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_SCAN: begin
                valid_o = 1'b1;
                idx_o   = low_idx;
                last_o  = (rest == '0);
            end
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hit_flag_sequencer.sv
module hit_flag_sequencer #(
    parameter int NUM_CH       = 64,
    parameter int LIFE         = 2,
    parameter int PULSE_CYCLES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         disc_i,
    input  logic                      wrap_i,
    output logic [NUM_CH-1:0]         snap_o,
    output logic                      mult_o,
    input  logic                      rd_start_i,
    input  logic [1:0]                rd_mode_i,
    input  logic [NUM_CH-1:0]         rd_mask_i,
    output logic                      ch_valid_o,
    output logic [$clog2(NUM_CH)-1:0] ch_idx_o,
    output logic                      ch_last_o,
    output logic                      rd_busy_o,
    output logic                      rd_done_o
);
    logic [NUM_CH-1:0] flags;
    logic              clr;
    logic              live;

    assign live = ~rd_busy_o;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
        hfs_hit_cell #(.LIFE(LIFE)) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .hit_i  (disc_i[c] & live),
            .wrap_i (wrap_i & live),
            .flag_o (flags[c])
        );
    end

    hfs_mult_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) pulse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i ((|disc_i) & live),
        .mult_o (mult_o)
    );

    hfs_rd_seq #(.NUM_CH(NUM_CH)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rd_start_i),
        .mode_i  (rd_mode_i),
        .mask_i  (rd_mask_i),
        .flags_i (flags),
        .clr_o   (clr),
        .valid_o (ch_valid_o),
        .idx_o   (ch_idx_o),
        .last_o  (ch_last_o),
        .busy_o  (rd_busy_o),
        .done_o  (rd_done_o)
    );

    assign snap_o = flags;
endmodule

// File: rtl/hit_flag_sequencer_chk.sv
module hit_flag_sequencer_chk #(
    parameter int NUM_CH = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         disc_i,
    input logic                      wrap_i,
    input logic [NUM_CH-1:0]         snap_o,
    input logic                      mult_o,
    input logic                      rd_start_i,
    input logic                      ch_valid_o,
    input logic [$clog2(NUM_CH)-1:0] ch_idx_o,
    input logic                      ch_last_o,
    input logic                      rd_busy_o,
    input logic                      rd_done_o
);
    assert_flag_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((snap_o & ~$past(snap_o) & ~$past(disc_i)) == '0));

    assert_pulse_two_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mult_o) |=> mult_o);

    assert_clear_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy_o |-> (snap_o == '0));

    assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid_o |-> rd_busy_o);

    assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_last_o |-> ch_valid_o);

    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid_o && !ch_last_o) |=> (ch_valid_o && (ch_idx_o > $past(ch_idx_o))));

    assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> (!rd_busy_o && !rd_done_o));

    assert_done_excl_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done_o && ch_valid_o));
endmodule

bind hit_flag_sequencer hit_flag_sequencer_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disc_i     (disc_i),
    .wrap_i     (wrap_i),
    .snap_o     (snap_o),
    .mult_o     (mult_o),
    .rd_start_i (rd_start_i),
    .ch_valid_o (ch_valid_o),
    .ch_idx_o   (ch_idx_o),
    .ch_last_o  (ch_last_o),
    .rd_busy_o  (rd_busy_o),
    .rd_done_o  (rd_done_o)
);

// File: tb/hit_flag_sequencer_tb.sv
module hit_flag_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  disc = '0;
    logic          wrap = 1'b0;
    logic [N-1:0]  snap;
    logic          mult;
    logic          rd_start = 1'b0;
    logic [1:0]    rd_mode = 2'd0;
    logic [N-1:0]  rd_mask = '0;
    logic          ch_valid;
    logic [5:0]    ch_idx;
    logic          ch_last;
    logic          rd_busy;
    logic          rd_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [N-1:0] m_flag = '0;
    int           m_age [N];
    int           m_mult = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_flag_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .disc_i(disc), .wrap_i(wrap),
        .snap_o(snap), .mult_o(mult), .rd_start_i(rd_start),
        .rd_mode_i(rd_mode), .rd_mask_i(rd_mask), .ch_valid_o(ch_valid),
        .ch_idx_o(ch_idx), .ch_last_o(ch_last), .rd_busy_o(rd_busy),
        .rd_done_o(rd_done)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic [N-1:0] d, input logic w, input bit busy, input bit clr);
        for (int c = 0; c < N; c++) begin
            if (clr) begin
                m_flag[c] = 1'b0; m_age[c] = 0;
            end else if (!busy) begin
                if (d[c]) begin
                    m_flag[c] = 1'b1; m_age[c] = 0;
                end else if (w && m_flag[c]) begin
                    if (m_age[c] == 1) begin m_flag[c] = 1'b0; m_age[c] = 0; end
                    else m_age[c]++;
                end
            end
        end
        if (!busy && (|d)) m_mult = 2;
        else if (m_mult > 0) m_mult--;
    endtask

    task automatic cyc(input logic [N-1:0] d, input logic w, input string tag);
        @(negedge clk);
        disc = d; wrap = w;
        @(posedge clk);
        model_edge(d, w, 0, 0);
        #(CLK_PERIOD/4);
        chk({tag, " snap"}, snap, m_flag);
        chk("R5 mult", N'(mult), N'(m_mult != 0));
    endtask

    function automatic int next_set(input logic [N-1:0] s, input int from);
        for (int c = from; c < N; c++) if (s[c]) return c;
        return N;
    endfunction

    task automatic readout(input logic [1:0] mode, input logic [N-1:0] mask, input string tag);
        logic [N-1:0] sel;
        int exp_c, got, total;
        bit fin;
        sel = (mode == 2'd0) ? {N{1'b1}} : (mode == 2'd1) ? m_flag : mask;
        total = $countones(sel);
        @(negedge clk);
        disc = '0; wrap = 1'b0; rd_start = 1'b1; rd_mode = mode; rd_mask = mask;
        @(posedge clk);
        model_edge('0, 1'b0, 0, 1);
        exp_c = next_set(sel, 0); got = 0; fin = 0;
        for (int t = 0; t < 80 && !fin; t++) begin
            #(CLK_PERIOD/4);
            chk("R6 snap during readout", snap, '0);
            chk("R6 mult during readout", N'(mult), N'(m_mult != 0));
            if (ch_valid) begin
                chk({tag, " R7 index"}, N'(ch_idx), N'(exp_c));
                chk({tag, " R7 last"}, N'(ch_last),
                    N'((sel & ~((64'd2 << exp_c) - 64'd1)) == '0));
                got++;
                exp_c = next_set(sel, exp_c + 1);
            end else if (rd_done) begin
                if (total == 0) chk({tag, " R8 done at once"}, N'(got), 0);
                chk({tag, " R9 count"}, N'(got), N'(total));
                fin = 1;
            end else begin
                chk({tag, " R7 idle gap"}, 1, 0);
                fin = 1;
            end
            @(negedge clk);
            disc = ($urandom % 2) ? N'(64'd1 << ($urandom % N)) : '0;
            wrap = ($urandom % 3) == 0;
            rd_start = fin ? 1'b0 : 1'b1;
            @(posedge clk);
            model_edge(disc, wrap, 1, 0);
        end
        #(CLK_PERIOD/4);
        chk({tag, " R9 busy low"}, N'(rd_busy), 0);
        chk({tag, " R9 done one cycle"}, N'(rd_done), 0);
        chk({tag, " R9 valid low"}, N'(ch_valid), 0);
        chk({tag, " R6 snap after"}, snap, '0);
        @(negedge clk);
        disc = '0; wrap = 1'b0;
        @(posedge clk);
        model_edge('0, 1'b0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < N; c++) m_age[c] = 0;
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        void'($urandom(32'h1badcafe));
        #(CLK_PERIOD * 3 + 2);
        chk("R1 snap in reset", snap, '0);
        chk("R1 ctrl in reset", N'({mult, ch_valid, ch_last, rd_busy, rd_done}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R1 snap after reset", snap, '0);
        chk("R1 ctrl after reset", N'({mult, ch_valid, ch_last, rd_busy, rd_done}), 0);

        cyc(N'(64'd1 << 5), 0, "R2 set ch5");
        cyc('0, 0, "R5 pulse tail");
        cyc('0, 0, "R5 pulse end");
        cyc('0, 1, "R3 first wrap keeps");
        cyc('0, 1, "R3 second wrap clears");
        cyc(N'(64'd1 << 9), 0, "R4 set ch9");
        cyc('0, 1, "R4 wrap one");
        cyc(N'(64'd1 << 9), 0, "R4 rehit ch9");
        cyc('0, 1, "R4 wrap after rehit");
        cyc(N'(64'd1 << 9), 1, "R4 hit with wrap");
        cyc('0, 1, "R4 wrap keeps");
        cyc('0, 1, "R4 wrap clears");
        cyc(N'(64'd1 << 63) | N'(1), 0, "R2 edge channels");
        cyc('0, 0, "R5 gap");
        cyc(N'(64'd1 << 2), 0, "R5 retrigger");
        cyc('0, 0, "R5 tail");

        readout(2'd1, '0, "hit mode");
        readout(2'd1, '0, "empty hit mode");
        readout(2'd0, '0, "all mode");
        readout(2'd2, 64'h8000_0001_0240_0010, "mask mode");
        readout(2'd3, 64'h0000_0000_0000_0000, "empty mask alt");
        readout(2'd3, 64'h0F00_0000_0000_8000, "mask alt mode");

        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k < 40; k++) begin
                d = '0;
                if (($urandom % 4) == 0) d = N'(64'd1 << ($urandom % N));
                if (($urandom % 16) == 0) d |= {$urandom, $urandom} & {$urandom, $urandom};
                cyc(d, ($urandom % 7) == 0, "R3 R4 random");
            end
            readout(2'($urandom % 4), {$urandom, $urandom}, "random readout");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule